// File: doc/BRIEF.md
# Clock and Data Source Mode Controller

This block chooses where a receiver's master clock and its serial data output come from. A 2-bit mode code picks one of four routings. Each routing names a clock source (the recovered-clock PLL or the crystal oscillator) and a data source (the received stream or an auxiliary serial input). It also sets power enables for the PLL and the crystal oscillator, and it picks which high-rate flag is passed to the output: the measured one or the one set by the host.

The mode code comes either from dedicated pins or from a control register, chosen by a select input. In the automatic mode the block drops from the PLL to the crystal when the PLL reports loss of lock, and it returns to the PLL when lock comes back. The unlock flag is asynchronous. It passes through a two-flop synchroniser and then a stability filter, so that short glitches never move the source. Downstream glitch-free clock switching is represented here only by a registered select.

Top module: `clk_data_src_ctrl`

## Requirements
- R1: Mode code 0 routes the PLL clock (`clk_sel`=0) and the received stream (`data_sel`=0), with `pll_en`=1 and `xtal_en`=0, one clock edge after the code is applied.
- R2: Mode code 1 routes the crystal (`clk_sel`=1) and the auxiliary input (`data_sel`=1), with `pll_en`=0 and `xtal_en`=1, one clock edge after the code is applied.
- R3: Mode code 2 with the PLL locked routes `clk_sel`=0 and `data_sel`=0, and keeps both `pll_en` and `xtal_en` at 1.
- R4: In mode code 2, once `pll_unlock` has been high on two consecutive clock edges, `clk_sel` and `data_sel` both become 1 on the fifth edge counted from the first edge that sampled it high, and not before. Lock returning is handled the same way in the opposite direction.
- R5: A `pll_unlock` pulse seen on only one clock edge never changes `clk_sel` or `data_sel`.
- R6: Mode code 3 routes `clk_sel`=1 and `data_sel`=1 with both enables at 1, and `pll_unlock` has no effect on the routing.
- R7: `rate_hi` equals `rate_meas` while `clk_sel`=0 and equals `rate_host` while `clk_sel`=1.
- R8: With `mode_from_reg`=1 the effective code is `mode_reg` and `mode_pin` is ignored. With `mode_from_reg`=0 the effective code is `mode_pin`.
- R9: While `rst_n` is low the outputs settle to `clk_sel`=0, `data_sel`=0, `pll_en`=1 and `xtal_en`=0.
- R10: `sdo` equals `rx_data` while `data_sel`=0 and equals `aux_data` while `data_sel`=1.
- R11: In mode code 0 `pll_unlock` has no effect on the routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pin | input | 2 | Mode code from dedicated pins |
| mode_reg | input | 2 | Mode code from control register |
| mode_from_reg | input | 1 | 1 selects `mode_reg`, 0 selects `mode_pin` |
| pll_unlock | input | 1 | Asynchronous PLL loss-of-lock flag |
| rx_data | input | 1 | Received serial data |
| aux_data | input | 1 | Auxiliary serial data input |
| rate_meas | input | 1 | High-rate flag measured from the received stream |
| rate_host | input | 1 | High-rate flag set by the host |
| clk_sel | output | 1 | Registered clock select, 0 PLL, 1 crystal |
| data_sel | output | 1 | Registered data select, 0 received, 1 auxiliary |
| sdo | output | 1 | Selected serial data output |
| rate_hi | output | 1 | High-rate flag for the selected clock source |
| pll_en | output | 1 | PLL power enable |
| xtal_en | output | 1 | Crystal oscillator power enable |

## Verification
The assertions take for granted that the reset is held across at least one clock edge. They also assume the synchroniser depth and stability count are at their default values, because the fall-back latency property is written for a five-edge path. They further assume that the mode code stays steady for two edges around any source switch that is checked, so that a mode change is never mistaken for an unlock response. The stimulus changes inputs only at falling edges, holds each mode for several cycles before it changes `pll_unlock`, and waits for the unlock filter to return to rest before it moves to the next mode.

// File: rtl/srcmode_pkg.sv
// Shared types for the clock/data source mode controller.
// Assumes a 2-bit mode code; each value maps to one routing.
package srcmode_pkg;

    typedef enum logic [1:0] {
        MODE_RX   = 2'd0,
        MODE_AUX  = 2'd1,
        MODE_AUTO = 2'd2,
        MODE_MON  = 2'd3
    } src_mode_e;

    typedef struct packed {
        logic clk_xtal;
        logic data_aux;
        logic pll_on;
        logic xtal_on;
    } route_t;

    localparam route_t ROUTE_RESET = '{clk_xtal: 1'b0, data_aux: 1'b0,
                                       pll_on: 1'b1, xtal_on: 1'b0};

endpackage

// File: rtl/unlock_filter.sv
// Synchronises the asynchronous unlock flag and accepts a new level only
// after it has held for STABLE_CYCLES edges. Assumes SYNC_STAGES >= 2.
module unlock_filter #(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock_async,
    output logic unlock_filt
);
    localparam int CW = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          hold_cnt;
    logic                   filt_q;

    // Synchroniser chain; stage 0 samples the asynchronous flag.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= unlock_async;
    end

    genvar g;
    generate
        for (g = 1; g < SYNC_STAGES; g++) begin : g_sync
            // One further synchroniser stage.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    endgenerate

    // Stability counter: adopt the synchronised level once it has differed long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            filt_q   <= 1'b0;
        end else if (sync_q[SYNC_STAGES-1] != filt_q) begin
            if (hold_cnt == CW'(STABLE_CYCLES - 1)) begin
                filt_q   <= sync_q[SYNC_STAGES-1];
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end else begin
            hold_cnt <= '0;
        end
    end

    assign unlock_filt = filt_q;

endmodule

// File: rtl/srcmode_decode.sv
// Combinational map from effective mode code and filtered unlock state to
// the next routing. Assumes unlock_filt is already synchronous.
module srcmode_decode
    import srcmode_pkg::*;
(
    input  logic [1:0] mode_code,
    input  logic       unlock_filt,
    output route_t     route_next
);
    // Routing table per mode; only the automatic mode consults unlock.
    always_comb begin
        route_next = ROUTE_RESET;
        unique case (src_mode_e'(mode_code))
            MODE_RX: begin
                route_next = '{clk_xtal: 1'b0, data_aux: 1'b0, pll_on: 1'b1, xtal_on: 1'b0};
            end
            MODE_AUX: begin
                route_next = '{clk_xtal: 1'b1, data_aux: 1'b1, pll_on: 1'b0, xtal_on: 1'b1};
            end
            MODE_AUTO: begin
                route_next = '{clk_xtal: unlock_filt, data_aux: unlock_filt,
                               pll_on: 1'b1, xtal_on: 1'b1};
            end
            MODE_MON: begin
                route_next = '{clk_xtal: 1'b1, data_aux: 1'b1, pll_on: 1'b1, xtal_on: 1'b1};
            end
            default: route_next = ROUTE_RESET;
        endcase
    end

endmodule

// File: rtl/clk_data_src_ctrl.sv
// Top of the clock/data source mode controller. Picks the mode code source,
// filters the unlock flag, registers the routing and drives the data and
// rate muxes from the registered selects. Assumes rst_n is synchronous.
module clk_data_src_ctrl
    import srcmode_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_pin,
    input  logic [1:0] mode_reg,
    input  logic       mode_from_reg,
    input  logic       pll_unlock,
    input  logic       rx_data,
    input  logic       aux_data,
    input  logic       rate_meas,
    input  logic       rate_host,
    output logic       clk_sel,
    output logic       data_sel,
    output logic       sdo,
    output logic       rate_hi,
    output logic       pll_en,
    output logic       xtal_en
);
    logic [1:0] mode_eff;
    logic       unlock_filt;
    route_t     route_next;
    route_t     route_q;

    // Effective mode code: register field or pins.
    assign mode_eff = mode_from_reg ? mode_reg : mode_pin;

    unlock_filter #(
        .SYNC_STAGES  (SYNC_STAGES),
        .STABLE_CYCLES(STABLE_CYCLES)
    ) u_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .unlock_async(pll_unlock),
        .unlock_filt (unlock_filt)
    );

    srcmode_decode u_decode (
        .mode_code  (mode_eff),
        .unlock_filt(unlock_filt),
        .route_next (route_next)
    );

    // Routing register standing in for the glitch-free switch control.
    always_ff @(posedge clk) begin
        if (!rst_n) route_q <= ROUTE_RESET;
        else        route_q <= route_next;
    end

    assign clk_sel  = route_q.clk_xtal;
    assign data_sel = route_q.data_aux;
    assign pll_en   = route_q.pll_on;
    assign xtal_en  = route_q.xtal_on;

    // Output muxes driven from the registered selects.
    assign sdo     = route_q.data_aux ? aux_data  : rx_data;
    assign rate_hi = route_q.clk_xtal ? rate_host : rate_meas;

endmodule

// File: rtl/clk_data_src_ctrl_chk.sv
// Property checker for clk_data_src_ctrl, attached by bind below.
// Assumes reset is held for at least one edge.
module clk_data_src_ctrl_chk #(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_pin,
    input logic [1:0] mode_reg,
    input logic       mode_from_reg,
    input logic       pll_unlock,
    input logic       rate_meas,
    input logic       rate_host,
    input logic       clk_sel,
    input logic       data_sel,
    input logic       rate_hi,
    input logic       pll_en,
    input logic       xtal_en
);
    logic [1:0] m_eff;
    assign m_eff = mode_from_reg ? mode_reg : mode_pin;

    // R1
    mode_rx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(m_eff) == 2'd0) |-> (!clk_sel && !data_sel && pll_en && !xtal_en));

    // R2
    mode_aux_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(m_eff) == 2'd1) |-> (clk_sel && data_sel && !pll_en && xtal_en));

    // R3
    mode_auto_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(m_eff) == 2'd2) |-> (pll_en && xtal_en && (clk_sel == data_sel)));

    // R6
    mode_mon_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(m_eff) == 2'd3) |-> (clk_sel && data_sel && pll_en && xtal_en));

    // R7
    rate_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_sel |-> (rate_hi == rate_meas));

    generate
        if (SYNC_STAGES == 2 && STABLE_CYCLES == 2) begin : g_lat
            // R4
            fallback_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(clk_sel) && $past(m_eff) == 2'd2 && $past(m_eff, 2) == 2'd2
                 && $past(rst_n, 5))
                |-> ($past(pll_unlock, 4) && $past(pll_unlock, 3)));
        end
    endgenerate

endmodule

bind clk_data_src_ctrl clk_data_src_ctrl_chk #(
    .SYNC_STAGES  (SYNC_STAGES),
    .STABLE_CYCLES(STABLE_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_pin     (mode_pin),
    .mode_reg     (mode_reg),
    .mode_from_reg(mode_from_reg),
    .pll_unlock   (pll_unlock),
    .rate_meas    (rate_meas),
    .rate_host    (rate_host),
    .clk_sel      (clk_sel),
    .data_sel     (data_sel),
    .rate_hi      (rate_hi),
    .pll_en       (pll_en),
    .xtal_en      (xtal_en)
);

// File: tb/clk_data_src_ctrl_test.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor pops and
// compares them a quarter period after each rising edge.
module clk_data_src_ctrl_test;

    typedef struct {
        logic  cs, ds, pe, xe, rt, sd;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_pin = 2'd0;
    logic [1:0] mode_reg = 2'd0;
    logic       mode_from_reg = 1'b0;
    logic       pll_unlock = 1'b0;
    logic       rx_data = 1'b1;
    logic       aux_data = 1'b0;
    logic       rate_meas = 1'b0;
    logic       rate_host = 1'b1;
    logic       clk_sel, data_sel, sdo, rate_hi, pll_en, xtal_en;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    clk_data_src_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .mode_reg(mode_reg),
        .mode_from_reg(mode_from_reg), .pll_unlock(pll_unlock),
        .rx_data(rx_data), .aux_data(aux_data), .rate_meas(rate_meas),
        .rate_host(rate_host), .clk_sel(clk_sel), .data_sel(data_sel),
        .sdo(sdo), .rate_hi(rate_hi), .pll_en(pll_en), .xtal_en(xtal_en)
    );

    // Driver helpers: wait edges, then queue the expected outputs.
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_out(input logic cs, ds, pe, xe, rt, sd, input string req);
        exp_t e;
        e.cs = cs; e.ds = ds; e.pe = pe; e.xe = xe; e.rt = rt; e.sd = sd; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compare one queued item per cycle, away from the edge.
    always @(posedge clk) begin
        #5;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if ({clk_sel, data_sel, pll_en, xtal_en, rate_hi, sdo} !=
                {e.cs, e.ds, e.pe, e.xe, e.rt, e.sd}) begin
                n_fail++;
                $display("FAIL %s: got cs=%b ds=%b pe=%b xe=%b rt=%b sdo=%b exp cs=%b ds=%b pe=%b xe=%b rt=%b sdo=%b",
                         e.req, clk_sel, data_sel, pll_en, xtal_en, rate_hi, sdo,
                         e.cs, e.ds, e.pe, e.xe, e.rt, e.sd);
            end
        end
    end

    // Stimulus sequence; inputs change only at falling edges.
    initial begin
        mode_pin = 2'd2;
        edges(2);
        expect_out(0, 0, 1, 0, 0, 1, "R9 reset");
        @(negedge clk);
        rst_n = 1'b1; mode_pin = 2'd0; rate_meas = 1'b1; rate_host = 1'b0;
        edges(1);
        expect_out(0, 0, 1, 0, 1, 1, "R1 R7 mode0");
        @(negedge clk);
        pll_unlock = 1'b1;
        edges(8);
        expect_out(0, 0, 1, 0, 1, 1, "R11 unlock in mode0");
        @(negedge clk);
        pll_unlock = 1'b0;
        edges(6);
        @(negedge clk);
        mode_pin = 2'd1;
        edges(1);
        expect_out(1, 1, 0, 1, 0, 0, "R2 R7 mode1");
        @(negedge clk);
        rate_host = 1'b1; aux_data = 1'b1;
        edges(1);
        expect_out(1, 1, 0, 1, 1, 1, "R7 R10 host rate aux data");
        @(negedge clk);
        mode_from_reg = 1'b1; mode_reg = 2'd0;
        edges(1);
        expect_out(0, 0, 1, 0, 1, 1, "R8 register code");
        @(negedge clk);
        mode_pin = 2'd3;
        edges(2);
        expect_out(0, 0, 1, 0, 1, 1, "R8 pins ignored");
        @(negedge clk);
        mode_from_reg = 1'b0; aux_data = 1'b0;
        edges(1);
        expect_out(1, 1, 1, 1, 1, 0, "R6 mode3");
        @(negedge clk);
        pll_unlock = 1'b1;
        edges(8);
        expect_out(1, 1, 1, 1, 1, 0, "R6 unlock in mode3");
        @(negedge clk);
        pll_unlock = 1'b0;
        edges(6);
        @(negedge clk);
        mode_pin = 2'd2;
        edges(1);
        expect_out(0, 0, 1, 1, 1, 1, "R3 mode2 locked");
        @(negedge clk);
        rx_data = 1'b0;
        edges(1);
        expect_out(0, 0, 1, 1, 1, 0, "R10 rx data");
        @(negedge clk);
        pll_unlock = 1'b1;
        @(negedge clk);
        pll_unlock = 1'b0;
        edges(6);
        expect_out(0, 0, 1, 1, 1, 0, "R5 short pulse");
        @(negedge clk);
        pll_unlock = 1'b1;
        edges(4);
        expect_out(0, 0, 1, 1, 1, 0, "R4 before fallback");
        edges(1);
        expect_out(1, 1, 1, 1, 1, 0, "R4 fallback");
        @(negedge clk);
        rate_host = 1'b0; aux_data = 1'b1;
        edges(1);
        expect_out(1, 1, 1, 1, 0, 1, "R7 R10 on crystal");
        @(negedge clk);
        pll_unlock = 1'b0;
        edges(4);
        expect_out(1, 1, 1, 1, 0, 1, "R4 before return");
        edges(1);
        expect_out(0, 0, 1, 1, 1, 0, "R4 return");
        edges(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule